// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small record of which event brought about the most recent reset. Boot firmware reads it to tell a fresh power-up from a warm restart. The block has four cause flags: power-on, the external reset pin, a watchdog timeout whose reset qualifier is enabled, and the brown-out detector. Each flag has its own set rule and its own clear rule, and one source can clear another source's flag.

The power-on indication is the only thing that initialises the block, so it belongs in an always-on domain that system resets do not reach. All event inputs arrive as digital levels or strobes that are already synchronous to the register clock, and they are sampled on every rising edge. Software reads the flags through a small register port. It clears any flag by writing a one to that flag's bit position.

Top module: `rst_cause_reg`

## Requirements
- R1: While `por_i` is high, every clock edge loads the flags with 4'b0001: power-on flag (bit 0) set, bits 1, 2 and 3 cleared. The registered read data is zero while `por_i` is high.
- R2: A write to `REG_ADDR` clears every flag whose bit in `bus_wdata_i[3:0]` is 1. Flags at bit positions written 0 keep their value. A write to any other address changes nothing.
- R3: A high `ext_rst_i` sets the pin flag (bit 1) at the next edge. Watchdog and brown-out events leave bit 1 unchanged.
- R4: A high `wdt_timeout_i` sets the watchdog flag (bit 2) only if `wdt_rst_en_i` is 1 in the same cycle. When the enable is 0 the timeout changes no flag.
- R5: A high `ext_rst_i` or `bod_i` clears bit 2. This clear takes priority over a watchdog set in the same cycle.
- R6: A high `bod_i` sets the brown-out flag (bit 3). External and watchdog events leave bit 3 unchanged.
- R7: A source that is still high when `por_i` falls sets its flag at the first edge after the release, on top of the power-on value.
- R8: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: The power-on flag (bit 0) is changed only by `por_i` and by software clears.
- R10: A read with `bus_rd_i` high at `REG_ADDR` returns the flags in `bus_rdata_o[3:0]` one cycle later, with all upper bits zero. In any other cycle `bus_rdata_o` is zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on register clock |
| por_i | input | 1 | Power-on reset indication, active high; the only initialiser |
| ext_rst_i | input | 1 | External reset pin level, active high |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe |
| wdt_rst_en_i | input | 1 | Watchdog reset-enable qualifier |
| bod_i | input | 1 | Brown-out detector output, active high |
| bus_addr_i | input | ADDR_W | Register port address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data; a one clears the flag at that bit |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W | Registered read data |
| cause_o | output | 4 | Current flags, for direct use by boot logic |

## Verification
The assertions check the per-cycle rules on every clock edge. These are the power-on load, the pin and brown-out set rules, the watchdog clear taking priority over a set, the gated watchdog leaving its flag unchanged, the power-on flag holding its value, and the read data returning to zero when the register is not selected. Other behaviours need an ordered series of events, and only the bench scenarios show them. These are a source still high as power-on ends, a software clear arriving in the same cycle as a set, writes of zeros and writes to other addresses, and a brown-out that runs on into a power-on reset and then recovers.

// File: rtl/rc_pkg.sv
package rc_pkg;

  localparam int unsigned N_CAUSE = 4;

  // Flag positions; software decodes these positions.
  localparam int unsigned IDX_POR = 0;
  localparam int unsigned IDX_PIN = 1;
  localparam int unsigned IDX_WDG = 2;
  localparam int unsigned IDX_BRN = 3;

  typedef logic [N_CAUSE-1:0] cause_vec_t;

  // Non-power-on sources that clear a given flag.
  function automatic cause_vec_t hw_clear_mask(input int unsigned idx);
    cause_vec_t m;
    m = '0;
    if (idx == IDX_WDG) begin
      m[IDX_PIN] = 1'b1;
      m[IDX_BRN] = 1'b1;
    end
    return m;
  endfunction

  // Value loaded into a flag while power-on is asserted.
  function automatic logic por_value(input int unsigned idx);
    return (idx == IDX_POR);
  endfunction

endpackage

// File: rtl/rc_event_map.sv
module rc_event_map
  import rc_pkg::*;
(
  input  logic       ext_rst_i,
  input  logic       wdt_timeout_i,
  input  logic       wdt_rst_en_i,
  input  logic       bod_i,
  output cause_vec_t set_o,
  output cause_vec_t hw_clr_o
);

  cause_vec_t src;

  always_comb begin
    src          = '0;
    src[IDX_PIN] = ext_rst_i;
    src[IDX_WDG] = wdt_timeout_i & wdt_rst_en_i;
    src[IDX_BRN] = bod_i;
  end

  assign set_o = src;

  for (genvar b = 0; b < N_CAUSE; b++) begin : g_clr
    localparam cause_vec_t CLR_MASK = hw_clear_mask(b);
    assign hw_clr_o[b] = |(src & CLR_MASK);
  end

endmodule

// File: rtl/rc_status_bit.sv
module rc_status_bit #(
  parameter logic POR_VAL = 1'b0
) (
  input  logic clk,
  input  logic por_i,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic sw_clr_i,
  output logic q_o
);

  // Priority: power-on, hardware clear, hardware set, software clear.
  always_ff @(posedge clk) begin
    if (por_i)         q_o <= POR_VAL;
    else if (hw_clr_i) q_o <= 1'b0;
    else if (set_i)    q_o <= 1'b1;
    else if (sw_clr_i) q_o <= 1'b0;
  end

endmodule

// File: rtl/rc_bus_port.sv
module rc_bus_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned N        = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      sw_clr_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned PAD_W = DATA_W - N;

  logic hit;
  logic unused_hi;

  assign hit       = (addr_i == REG_ADDR);
  assign sw_clr_o  = (wr_i && hit) ? wdata_i[N-1:0] : '0;
  assign unused_hi = ^wdata_i[DATA_W-1:N];

  always_ff @(posedge clk) begin
    if (por_i)             rdata_o <= '0;
    else if (rd_i && hit)  rdata_o <= {{PAD_W{1'b0}}, status_i};
    else                   rdata_o <= '0;
  end

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              ext_rst_i,
  input  logic              wdt_timeout_i,
  input  logic              wdt_rst_en_i,
  input  logic              bod_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [3:0]        cause_o
);

  cause_vec_t set_v;
  cause_vec_t hw_clr_v;
  cause_vec_t sw_clr_v;
  cause_vec_t flags;

  rc_event_map u_map (
    .ext_rst_i     (ext_rst_i),
    .wdt_timeout_i (wdt_timeout_i),
    .wdt_rst_en_i  (wdt_rst_en_i),
    .bod_i         (bod_i),
    .set_o         (set_v),
    .hw_clr_o      (hw_clr_v)
  );

  for (genvar b = 0; b < N_CAUSE; b++) begin : g_flag
    rc_status_bit #(.POR_VAL(por_value(b))) u_bit (
      .clk      (clk),
      .por_i    (por_i),
      .set_i    (set_v[b]),
      .hw_clr_i (hw_clr_v[b]),
      .sw_clr_i (sw_clr_v[b]),
      .q_o      (flags[b])
    );
  end

  rc_bus_port #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .N        (N_CAUSE),
    .REG_ADDR (REG_ADDR)
  ) u_bus (
    .clk      (clk),
    .por_i    (por_i),
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .wdata_i  (bus_wdata_i),
    .rd_i     (bus_rd_i),
    .status_i (flags),
    .sw_clr_o (sw_clr_v),
    .rdata_o  (bus_rdata_o)
  );

  assign cause_o = flags;

endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input logic              clk,
  input logic              por_i,
  input logic              ext_rst_i,
  input logic              wdt_timeout_i,
  input logic              wdt_rst_en_i,
  input logic              bod_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              bus_rd_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [3:0]        cause_o
);

  logic seen_por = 1'b0;
  always_ff @(posedge clk) if (por_i) seen_por <= 1'b1;

  logic [3:0] wclr;
  assign wclr = (bus_wr_i && bus_addr_i == REG_ADDR) ? bus_wdata_i[3:0] : 4'b0;

  p_por_load_r1: assert property (@(posedge clk) disable iff (!seen_por)
    por_i |=> (cause_o == 4'b0001 && bus_rdata_o == '0));

  p_pin_set_r3: assert property (@(posedge clk) disable iff (!seen_por)
    (!por_i && ext_rst_i) |=> cause_o[1]);

  p_wdg_gated_r4: assert property (@(posedge clk) disable iff (!seen_por)
    (!por_i && !wdt_rst_en_i && !ext_rst_i && !bod_i && !wclr[2]) |=> $stable(cause_o[2]));

  p_wdg_clear_r5: assert property (@(posedge clk) disable iff (!seen_por)
    (!por_i && (ext_rst_i || bod_i)) |=> !cause_o[2]);

  p_brn_set_r6: assert property (@(posedge clk) disable iff (!seen_por)
    (!por_i && bod_i) |=> cause_o[3]);

  p_por_hold_r9: assert property (@(posedge clk) disable iff (!seen_por)
    (!por_i && !wclr[0]) |=> $stable(cause_o[0]));

  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!seen_por)
    !(bus_rd_i && bus_addr_i == REG_ADDR) |=> bus_rdata_o == '0);

endmodule

bind rst_cause_reg rst_cause_reg_chk #(
  .DATA_W (DATA_W), .ADDR_W (ADDR_W), .REG_ADDR (REG_ADDR)
) u_chk (.*);

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] RA = 8'h10;

  logic          clk = 1'b0;
  logic          por = 1'b1;
  logic          ext = 1'b0;
  logic          wto = 1'b0;
  logic          wen = 1'b0;
  logic          bod = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          rd = 1'b0;
  logic [DW-1:0] rdata;
  logic [3:0]    cause;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  rst_cause_reg #(.DATA_W(DW), .ADDR_W(AW), .REG_ADDR(RA)) u_dut (
    .clk(clk), .por_i(por), .ext_rst_i(ext), .wdt_timeout_i(wto),
    .wdt_rst_en_i(wen), .bod_i(bod), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata), .cause_o(cause)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [AW-1:0] a, input logic [3:0] d);
    addr = a; wdata = {{(DW-4){1'b1}}, d}; wr = 1'b1;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic t_power_up();
    por = 1'b1; bod = 1'b1; ext = 1'b1;
    step(); step();
    chk("R1", {28'd0, cause}, 32'h1);
    chk("R1", rdata, 32'h0);
    por = 1'b0;
    step();
    chk("R7", {28'd0, cause}, 32'hB);
    bod = 1'b0; ext = 1'b0;
    step();
    chk("R7", {28'd0, cause}, 32'hB);
  endtask

  task automatic t_clear();
    write_reg(RA, 4'b0000);
    chk("R2", {28'd0, cause}, 32'hB);
    write_reg(RA + 8'd1, 4'b1111);
    chk("R2", {28'd0, cause}, 32'hB);
    write_reg(RA, 4'b1111);
    chk("R2", {28'd0, cause}, 32'h0);
  endtask

  task automatic t_pin_and_wdg();
    ext = 1'b1; step(); ext = 1'b0;
    chk("R3", {28'd0, cause}, 32'h2);
    chk("R9", {31'd0, cause[0]}, 32'h0);
    wto = 1'b1; wen = 1'b0; step(); wto = 1'b0;
    chk("R4", {28'd0, cause}, 32'h2);
    wto = 1'b1; wen = 1'b1; step(); wto = 1'b0; wen = 1'b0;
    chk("R4", {28'd0, cause}, 32'h6);
  endtask

  task automatic t_brownout();
    bod = 1'b1; step(); bod = 1'b0;
    chk("R6", {28'd0, cause}, 32'hA);
    chk("R5", {31'd0, cause[2]}, 32'h0);
    wto = 1'b1; wen = 1'b1; step(); wto = 1'b0;
    chk("R6", {28'd0, cause}, 32'hE);
    ext = 1'b1; step(); ext = 1'b0;
    chk("R5", {28'd0, cause}, 32'hA);
    wto = 1'b1; bod = 1'b1; step(); wto = 1'b0; bod = 1'b0; wen = 1'b0;
    chk("R5", {28'd0, cause}, 32'hA);
  endtask

  task automatic t_set_wins();
    ext = 1'b1;
    write_reg(RA, 4'b0010);
    ext = 1'b0;
    chk("R8", {28'd0, cause}, 32'hA);
    bod = 1'b1;
    write_reg(RA, 4'b1010);
    bod = 1'b0;
    chk("R8", {28'd0, cause}, 32'h8);
  endtask

  task automatic t_read();
    addr = RA; rd = 1'b1; step(); rd = 1'b0;
    chk("R10", rdata, 32'h8);
    addr = RA + 8'd2; rd = 1'b1; step(); rd = 1'b0;
    chk("R10", rdata, 32'h0);
  endtask

  task automatic t_por_again();
    ext = 1'b1; step(); ext = 1'b0;
    chk("R3", {28'd0, cause}, 32'hA);
    bod = 1'b1; por = 1'b1; step(); step();
    chk("R1", {28'd0, cause}, 32'h1);
    por = 1'b0; step(); bod = 1'b0;
    chk("R7", {28'd0, cause}, 32'h9);
    write_reg(RA, 4'b0001);
    chk("R9", {28'd0, cause}, 32'h8);
  endtask

  initial begin
    @(negedge clk);
    t_power_up();
    t_clear();
    t_pin_and_wdg();
    t_brownout();
    t_set_wins();
    t_read();
    t_por_again();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule